// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesizer

This block is a direct digital synthesis core for an 8-bit DAC. A phase accumulator adds a tuning word on every clock and wraps when it overflows, so one full wrap is one output period. With a 200 MHz clock and a 32-bit accumulator, one tuning-word step comes to roughly 0.047 Hz. The upper bits of the accumulator form a phase index. Shape generators turn that index into a sine, saw, ramp, triangle, square or saw-triangle sample. An encoded selector picks which shape reaches the sample output.

The sine comes from a 256-entry, 8-bit table that is read synchronously. Every other shape is registered once, so all shapes have the same one-cycle latency. A separate 1-bit fast square output follows the accumulator MSB directly. The noise code and all unassigned codes give a constant midscale value.

Top module: `dds_wavegen`

## Requirements
- R1: On each rising clock edge out of reset, the accumulator adds `tune_word_i` modulo 2^32. The phase index is accumulator bits [31:24].
- R2: Synchronous reset clears the accumulator and selects sine. While reset is held, `square_o` is 0 and `sample_o` is 128, the sine of index 0.
- R3: `sample_o` in a cycle is the shape of the phase index and selector code that were present in the previous cycle, which is a one-cycle latency.
- R4: Code 0 (sine) outputs 128 + 127*sin(2*pi*index/256), accurate to within 1 LSB.
- R5: Code 1 (saw) outputs the phase index itself.
- R6: Code 2 (ramp) outputs (256 - index) mod 256.
- R7: Code 3 (triangle) outputs 2*index for index below 128, and 2*(255 - index) otherwise.
- R8: Code 4 (square) outputs 255 when the index exceeds 127, and 0 otherwise.
- R9: Code 5 (saw-triangle) outputs (256 - index) mod 256 when the index exceeds 127, and 127 + index otherwise.
- R10: Code 6 (noise placeholder) and every code from 7 to 255 output 127.
- R11: `square_o` equals accumulator bit 31 with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tune_word_i | input | 32 | Phase increment added every clock |
| wave_sel_i | input | 8 | Waveform code |
| sample_o | output | 8 | DAC sample |
| square_o | output | 1 | Fast square output (accumulator MSB) |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, an 8-bit sample and index, and an 8-bit selector. It drives a tuning word of 2^24, so the phase index steps by exactly one per clock. In that way 256 cycles visit every index of every shape, including the fold points at 127/128 and the wrap from 255 back to 0. A half-step word and an all-ones word exercise the carry from the lower accumulator bits and the wrap downward. A quarter-turn word toggles the fast square output every other cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int WAVE_SINE    = 0;
    localparam int WAVE_SAW     = 1;
    localparam int WAVE_RAMP    = 2;
    localparam int WAVE_TRI     = 3;
    localparam int WAVE_SQUARE  = 4;
    localparam int WAVE_SAWTRI  = 5;
    localparam int WAVE_NOISE   = 6;

    // Sine table entry for index i of a w-bit table, built with a rational
    // half-wave approximation: s(t) = 16t(N-t) / (5N^2 - 4t(N-t)).
    function automatic int sine_entry(input int i, input int w);
        longint n;
        longint amp;
        longint t;
        longint p;
        longint num;
        longint den;
        longint mag;
        n   = longint'(1) << (w - 1);
        amp = n - 1;
        t   = longint'(i) % n;
        p   = t * (n - t);
        num = 16 * p * amp;
        den = 5 * n * n - 4 * p;
        mag = (num + den / 2) / den;
        if (longint'(i) < n) begin
            return int'(n + mag);
        end
        return int'(n - mag);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] tune_word_i,
    output logic [ACC_W-1:0] phase_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t state_d;
    acc_state_t state_q;

    always_comb begin
        state_d     = state_q;
        state_d.acc = state_q.acc + tune_word_i;
        if (rst_i) begin
            state_d.acc = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign phase_o = state_q.acc;

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk_i,
    input  logic [SAMPLE_W-1:0] addr_i,
    output logic [SAMPLE_W-1:0] data_o
);

    localparam int DEPTH = 1 << SAMPLE_W;

    logic [SAMPLE_W-1:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [SAMPLE_W-1:0] ENTRY = SAMPLE_W'(dds_pkg::sine_entry(g, SAMPLE_W));
        assign table_w[g] = ENTRY;
    end

    logic [SAMPLE_W-1:0] data_d;
    logic [SAMPLE_W-1:0] data_q;

    always_comb begin
        data_d = table_w[addr_i];
    end

    always_ff @(posedge clk_i) begin
        data_q <= data_d;
    end

    assign data_o = data_q;

endmodule

// File: rtl/dds_shaper.sv
module dds_shaper #(
    parameter int SAMPLE_W = 8,
    parameter int SEL_W    = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [SAMPLE_W-1:0] index_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic [SAMPLE_W-1:0] shape_o,
    output logic                use_sine_o
);

    localparam logic [SAMPLE_W-1:0] MID_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] MAX_V = '1;

    typedef struct packed {
        logic [SAMPLE_W-1:0] shape;
        logic                use_sine;
    } shape_state_t;

    shape_state_t state_d;
    shape_state_t state_q;

    logic [SAMPLE_W-1:0] saw_w;
    logic [SAMPLE_W-1:0] ramp_w;
    logic [SAMPLE_W-1:0] tri_w;
    logic [SAMPLE_W-1:0] sq_w;
    logic [SAMPLE_W-1:0] sawtri_w;
    logic                upper_w;

    always_comb begin
        saw_w    = index_i;
        ramp_w   = -index_i;
        upper_w  = index_i > MID_V;
        tri_w    = upper_w ? ((~index_i) << 1) : (index_i << 1);
        sq_w     = upper_w ? MAX_V : '0;
        sawtri_w = upper_w ? ramp_w : (MID_V + index_i);
    end

    always_comb begin
        state_d          = state_q;
        state_d.use_sine = (sel_i == SEL_W'(dds_pkg::WAVE_SINE));
        case (sel_i)
            SEL_W'(dds_pkg::WAVE_SAW):    state_d.shape = saw_w;
            SEL_W'(dds_pkg::WAVE_RAMP):   state_d.shape = ramp_w;
            SEL_W'(dds_pkg::WAVE_TRI):    state_d.shape = tri_w;
            SEL_W'(dds_pkg::WAVE_SQUARE): state_d.shape = sq_w;
            SEL_W'(dds_pkg::WAVE_SAWTRI): state_d.shape = sawtri_w;
            SEL_W'(dds_pkg::WAVE_NOISE):  state_d.shape = MID_V;
            default:                      state_d.shape = MID_V;
        endcase
        if (rst_i) begin
            state_d.shape    = MID_V;
            state_d.use_sine = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign shape_o    = state_q.shape;
    assign use_sine_o = state_q.use_sine;

endmodule

// File: rtl/dds_wavegen.sv
module dds_wavegen #(
    parameter int ACC_W    = 32,
    parameter int SAMPLE_W = 8,
    parameter int SEL_W    = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [ACC_W-1:0]    tune_word_i,
    input  logic [SEL_W-1:0]    wave_sel_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                square_o
);

    logic [ACC_W-1:0]    phase_w;
    logic [SAMPLE_W-1:0] index_w;
    logic [SAMPLE_W-1:0] sine_w;
    logic [SAMPLE_W-1:0] shape_w;
    logic                use_sine_w;

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tune_word_i (tune_word_i),
        .phase_o     (phase_w)
    );

    assign index_w = phase_w[ACC_W-1 -: SAMPLE_W];

    dds_sine_rom #(.SAMPLE_W(SAMPLE_W)) u_sine (
        .clk_i  (clk_i),
        .addr_i (index_w),
        .data_o (sine_w)
    );

    dds_shaper #(.SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W)) u_shape (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .index_i    (index_w),
        .sel_i      (wave_sel_i),
        .shape_o    (shape_w),
        .use_sine_o (use_sine_w)
    );

    assign sample_o = use_sine_w ? sine_w : shape_w;
    assign square_o = phase_w[ACC_W-1];

endmodule

// File: rtl/dds_wavegen_chk.sv
module dds_wavegen_chk #(
    parameter int ACC_W    = 32,
    parameter int SAMPLE_W = 8,
    parameter int SEL_W    = 8
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic [ACC_W-1:0]    tune_word_i,
    input logic [SEL_W-1:0]    wave_sel_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                square_o
);

    localparam logic [SAMPLE_W-1:0] MID_V  = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] MAX_V  = '1;
    localparam logic [ACC_W-1:0]    UNIT_W = ACC_W'(1) << (ACC_W - SAMPLE_W);
    localparam logic [SEL_W-1:0]    C_SAW  = SEL_W'(dds_pkg::WAVE_SAW);
    localparam logic [SEL_W-1:0]    C_RAMP = SEL_W'(dds_pkg::WAVE_RAMP);
    localparam logic [SEL_W-1:0]    C_TRI  = SEL_W'(dds_pkg::WAVE_TRI);
    localparam logic [SEL_W-1:0]    C_SQ   = SEL_W'(dds_pkg::WAVE_SQUARE);
    localparam logic [SEL_W-1:0]    C_NOI  = SEL_W'(dds_pkg::WAVE_NOISE);

    AST_HOLD_ON_ZERO_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(tune_word_i) == '0) |-> $stable(square_o)); // R1

    AST_SAW_STEPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2) && $past(wave_sel_i) == C_SAW
         && $past(wave_sel_i, 2) == C_SAW && $past(tune_word_i, 2) == UNIT_W)
        |-> sample_o == $past(sample_o) + SAMPLE_W'(1)); // R5

    AST_RAMP_STEPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2) && $past(wave_sel_i) == C_RAMP
         && $past(wave_sel_i, 2) == C_RAMP && $past(tune_word_i, 2) == UNIT_W)
        |-> sample_o == $past(sample_o) - SAMPLE_W'(1)); // R6

    AST_TRI_EVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(wave_sel_i) == C_TRI) |-> sample_o[0] == 1'b0); // R7

    AST_SQUARE_RAILS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(wave_sel_i) == C_SQ)
        |-> (sample_o == '0 || sample_o == MAX_V)); // R8

    AST_MIDSCALE_CODES: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(wave_sel_i) >= C_NOI) |-> sample_o == MID_V); // R10

endmodule

bind dds_wavegen dds_wavegen_chk #(
    .ACC_W    (ACC_W),
    .SAMPLE_W (SAMPLE_W),
    .SEL_W    (SEL_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tune_word_i (tune_word_i),
    .wave_sel_i  (wave_sel_i),
    .sample_o    (sample_o),
    .square_o    (square_o)
);

// File: tb/tb_dds_wavegen.sv
`timescale 1ns/1ps
module tb_dds_wavegen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tw  = '0;
    logic [7:0]  sel = '0;
    logic [7:0]  sample;
    logic        square;

    int total = 0;
    int fails = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    logic [31:0] acc_m = '0;
    logic [7:0]  idx_prev = '0;
    logic [7:0]  sel_prev = '0;

    always #2 clk = ~clk;

    dds_wavegen dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .tune_word_i (tw),
        .wave_sel_i  (sel),
        .sample_o    (sample),
        .square_o    (square)
    );

    // reference model of the accumulator and the one-cycle output pipe (R1, R3)
    always @(posedge clk) begin
        idx_prev <= acc_m[31:24];
        sel_prev <= rst ? 8'd0 : sel;
        acc_m    <= rst ? 32'd0 : acc_m + tw;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int shape_exp(input int idx, input int code);
        case (code)
            1: return idx;
            2: return (256 - idx) % 256;
            3: return (idx < 128) ? 2 * idx : 2 * (255 - idx);
            4: return (idx > 127) ? 255 : 0;
            5: return (idx > 127) ? (256 - idx) % 256 : 127 + idx;
            default: return 127;
        endcase
    endfunction

    function automatic string shape_tag(input int code);
        case (code)
            0: return "R4 sine";
            1: return "R5 saw";
            2: return "R6 ramp";
            3: return "R7 triangle";
            4: return "R8 square";
            5: return "R9 saw-triangle";
            default: return "R10 midscale";
        endcase
    endfunction

    always @(negedge clk) begin
        if (chk_en) begin
            int e;
            real s;
            check(square == acc_m[31], "R11 R1 square_o", int'(square), int'(acc_m[31]));
            if (sel_prev == 8'd0) begin
                s = 128.0 + 127.0 * $sin(6.283185307179586 * real'(idx_prev) / 256.0);
                e = $rtoi(s + 0.5);
                check((int'(sample) - e <= 1) && (e - int'(sample) <= 1),
                      "R4 R3 sine", int'(sample), e);
            end else begin
                e = shape_exp(int'(idx_prev), int'(sel_prev));
                check(int'(sample) == e, shape_tag(int'(sel_prev)), int'(sample), e);
            end
        end
    end

    task automatic run(input logic [7:0] code, input logic [31:0] word, input int n);
        @(negedge clk);
        sel = code;
        tw  = word;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(4.0 * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(square == 1'b0, "R2 reset square", int'(square), 0);
        check(sample == 8'd128, "R2 reset sample", int'(sample), 128);
        tw = 32'h0300_0000;
        sel = 8'd1;
        @(negedge clk);
        check(sample == 8'd128, "R2 reset holds sine", int'(sample), 128);
        check(square == 1'b0, "R2 reset holds acc", int'(square), 0);
        rst = 1'b0;
        chk_en = 1'b1;
        for (int c = 0; c < 8; c++) begin
            run(8'(c), 32'h0100_0000, 260);
        end
        run(8'd255, 32'h0100_0000, 20);
        run(8'd128, 32'h0100_0000, 20);
        run(8'd1, 32'h0080_0000, 520);
        run(8'd3, 32'hFFFF_FFFF, 300);
        run(8'd4, 32'h4000_0000, 40);
        run(8'd1, 32'h0000_0000, 20);
        for (int k = 0; k < 40; k++) begin
            run(8'(k % 7), 32'h0123_4567 * 32'(k + 1), 3);
        end
        chk_en = 1'b0;
        done = 1'b1;
        summary();
    end

endmodule